// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on its own write clock and a consumer pulls them on its own read clock. The pointers cross between the domains in Gray code through two-stage synchronisers. The empty condition is judged on the read side and the full condition on the write side.

The read-side timing is chosen once, at master reset, from the level of a mode-select input. In standard mode a word reaches the output only when the consumer asks for it. In fall-through mode the oldest word is placed on the output without a request. In that mode the two status pins report "data ready" and "room available" instead of empty and full. A partial reset empties the buffer and keeps the chosen mode. A half-full flag is available in both modes.

Top module: `dcf_fifo`

## Requirements
- R1: The level of `mode_sel` at the clock edges during which `mrst` is high selects the mode: 0 is standard, 1 is fall-through. A change of `mode_sel` while `mrst` is low has no effect.
- R2: In standard mode `rdata` changes only at a rising `rclk` edge where `ren` is 1 and the buffer is not empty. After that edge it holds the oldest unread word.
- R3: In fall-through mode, a word written into an empty buffer appears on `rdata` at the third rising `rclk` edge after the write edge, and `rd_status` rises with it. `ren` is not needed.
- R4: In fall-through mode, a presented word stays on `rdata` until a rising `rclk` edge with `ren` at 1. That edge presents the next word, or clears `rd_status` if no word is left.
- R5: In standard mode `rd_status` is 1 when the buffer is empty and `wr_status` is 1 when it is full. In fall-through mode `rd_status` is 1 when a word is on `rdata` and `wr_status` is 1 while storage has room.
- R6: `half_full` is 1, as seen in the write domain, while the storage memory holds more than DEPTH/2 words. In fall-through mode the word already on `rdata` is not counted. The storage memory holds DEPTH words.
- R7: A write while storage is full and a standard-mode read while empty are dropped. Neither one disturbs the order or content of the words that follow.
- R8: Master reset empties the buffer and sets `rdata` to 0. Standard mode leaves reset with `rd_status`=1 and `wr_status`=0, fall-through mode with `rd_status`=0 and `wr_status`=1. `half_full` is 0 in both.
- R9: Partial reset empties the buffer and sets `rdata` to 0, as master reset does, but keeps the mode chosen at the last master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wen | input | 1 | Write request |
| wdata | input | DATA_W | Word to write |
| rclk | input | 1 | Read-domain clock |
| ren | input | 1 | Read request |
| rdata | output | DATA_W | Output word |
| mrst | input | 1 | Master reset, active high, sampled by both clocks |
| prst | input | 1 | Partial reset, active high, sampled by both clocks |
| mode_sel | input | 1 | Mode choice sampled during master reset |
| rd_status | output | 1 | Empty (standard) or output ready (fall-through) |
| wr_status | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | Storage holds more than DEPTH/2 words |

## Verification
The properties assume that each reset stays high across at least two rising edges of both clocks, and that `mode_sel` is steady while master reset is high. They are checked only outside resets, so a reset that arrives in the middle of traffic simply disables them. The stimulus holds every reset for four read-clock edges, changes `mode_sel` only after release, and drives the clocks at periods whose rising edges never coincide. The three-edge fall-through latency is then a fixed count and not a race.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.stage1 = din;
        st_d.stage2 = st_q.stage1;
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.stage2;

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              mode_sel,
    input  logic              wen,
    input  logic [ADDR_W:0]   rd_gray_s,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              wr_status,
    output logic              half_full,
    output logic              full,
    output logic [ADDR_W:0]   level,
    output fifo_mode_e        mode
);

    localparam int              DEPTH     = 1 << ADDR_W;
    localparam int              PW        = ADDR_W + 1;
    localparam logic [PW-1:0]   ONE       = PW'(1);
    localparam logic [PW-1:0]   FULL_LVL  = PW'(DEPTH);
    localparam logic [PW-1:0]   HALF_LVL  = PW'(DEPTH / 2);

    typedef struct packed {
        fifo_mode_e    mode;
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [PW-1:0] rd_bin_s;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        rd_bin_s = from_gray(rd_gray_s);
        level    = st_q.bin - rd_bin_s;
        full     = (level == FULL_LVL);
        mem_we   = wen && !full && !mrst && !prst;

        st_d = st_q;
        if (mem_we) begin
            st_d.bin  = st_q.bin + ONE;
            st_d.gray = to_gray(st_d.bin);
        end
        if (mrst || prst) begin
            st_d.bin  = '0;
            st_d.gray = '0;
        end
        if (mrst) begin
            st_d.mode = fifo_mode_e'(mode_sel);
        end
    end

    always_ff @(posedge wclk) begin
        st_q <= st_d;
    end

    assign mem_waddr = st_q.bin[ADDR_W-1:0];
    assign wr_gray   = st_q.gray;
    assign mode      = st_q.mode;
    assign wr_status = (st_q.mode == MODE_FWFT) ? !full : full;
    assign half_full = (level > HALF_LVL);

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              mode_sel,
    input  logic              ren,
    input  logic [ADDR_W:0]   wr_gray_s,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   rd_gray,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_status,
    output logic              stor_empty,
    output fifo_mode_e        mode
);

    localparam int            PW  = ADDR_W + 1;
    localparam logic [PW-1:0] ONE = PW'(1);

    typedef struct packed {
        fifo_mode_e        mode;
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic [DATA_W-1:0] dout;
        logic              valid;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [PW-1:0] wr_bin_s;
    logic          take;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        wr_bin_s   = from_gray(wr_gray_s);
        stor_empty = (st_q.bin == wr_bin_s);

        if (st_q.mode == MODE_STD) begin
            take = ren && !stor_empty;
        end else begin
            take = !stor_empty && (!st_q.valid || ren);
        end

        st_d = st_q;
        if (take) begin
            st_d.dout  = mem_rdata;
            st_d.bin   = st_q.bin + ONE;
            st_d.gray  = to_gray(st_d.bin);
            st_d.valid = (st_q.mode == MODE_FWFT);
        end else if (ren && st_q.valid) begin
            st_d.valid = 1'b0;
        end

        if (mrst || prst) begin
            st_d.bin   = '0;
            st_d.gray  = '0;
            st_d.dout  = '0;
            st_d.valid = 1'b0;
        end
        if (mrst) begin
            st_d.mode = fifo_mode_e'(mode_sel);
        end
    end

    always_ff @(posedge rclk) begin
        st_q <= st_d;
    end

    assign mem_raddr = st_q.bin[ADDR_W-1:0];
    assign rd_gray   = st_q.gray;
    assign rdata     = st_q.dout;
    assign mode      = st_q.mode;
    assign rd_status = (st_q.mode == MODE_FWFT) ? st_q.valid : stor_empty;

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              ren,
    output logic [DATA_W-1:0] rdata,
    input  logic              mrst,
    input  logic              prst,
    input  logic              mode_sel,
    output logic              rd_status,
    output logic              wr_status,
    output logic              half_full
);

    localparam int PW = ADDR_W + 1;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PW-1:0]     wr_gray;
    logic [PW-1:0]     rd_gray;
    logic [PW-1:0]     wr_gray_s;
    logic [PW-1:0]     rd_gray_s;
    logic              wr_full;
    logic [PW-1:0]     wr_level;
    logic              rd_stor_empty;
    fifo_mode_e        wr_mode;
    fifo_mode_e        rd_mode;
    logic              wr_clr;
    logic              rd_clr;

    assign wr_clr = mrst || prst;
    assign rd_clr = mrst || prst;

    dcf_mem #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dcf_sync #(.W(PW)) u_sync_to_rd (
        .clk  (rclk),
        .clr  (rd_clr),
        .din  (wr_gray),
        .dout (wr_gray_s)
    );

    dcf_sync #(.W(PW)) u_sync_to_wr (
        .clk  (wclk),
        .clr  (wr_clr),
        .din  (rd_gray),
        .dout (rd_gray_s)
    );

    dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .wclk      (wclk),
        .mrst      (mrst),
        .prst      (prst),
        .mode_sel  (mode_sel),
        .wen       (wen),
        .rd_gray_s (rd_gray_s),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .wr_gray   (wr_gray),
        .wr_status (wr_status),
        .half_full (half_full),
        .full      (wr_full),
        .level     (wr_level),
        .mode      (wr_mode)
    );

    dcf_rd_ctl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .rclk       (rclk),
        .mrst       (mrst),
        .prst       (prst),
        .mode_sel   (mode_sel),
        .ren        (ren),
        .wr_gray_s  (wr_gray_s),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rd_gray    (rd_gray),
        .rdata      (rdata),
        .rd_status  (rd_status),
        .stor_empty (rd_stor_empty),
        .mode       (rd_mode)
    );

endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk
    import dcf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              wclk,
    input logic              rclk,
    input logic              mrst,
    input logic              prst,
    input logic              wen,
    input logic              ren,
    input logic [DATA_W-1:0] rdata,
    input logic              rd_status,
    input logic              wr_full,
    input logic [ADDR_W:0]   wr_level,
    input logic [ADDR_W:0]   wr_gray,
    input logic [ADDR_W:0]   rd_gray,
    input logic              rd_stor_empty,
    input fifo_mode_e        wr_mode,
    input fifo_mode_e        rd_mode
);

    localparam int            PW       = ADDR_W + 1;
    localparam logic [PW-1:0] FULL_LVL = PW'(1 << ADDR_W);

    p_write_dropped_full_r7: assert property (
        @(posedge wclk) disable iff (mrst || prst)
        (wr_full && wen) |=> $stable(wr_gray)
    );

    p_read_dropped_empty_r7: assert property (
        @(posedge rclk) disable iff (mrst || prst)
        (rd_mode == MODE_STD && rd_stor_empty && ren) |=> $stable(rd_gray)
    );

    p_level_in_range_r6: assert property (
        @(posedge wclk) disable iff (mrst || prst)
        wr_level <= FULL_LVL
    );

    p_std_output_held_r2: assert property (
        @(posedge rclk) disable iff (mrst || prst)
        (rd_mode == MODE_STD && !ren) |=> $stable(rdata)
    );

    p_fwft_word_held_r4: assert property (
        @(posedge rclk) disable iff (mrst || prst)
        (rd_mode == MODE_FWFT && rd_status && !ren) |=> (rd_status && $stable(rdata))
    );

    p_rd_mode_kept_r9: assert property (
        @(posedge rclk) disable iff (mrst)
        prst |=> $stable(rd_mode)
    );

    p_wr_mode_kept_r9: assert property (
        @(posedge wclk) disable iff (mrst)
        prst |=> $stable(wr_mode)
    );

endmodule

bind dcf_fifo dcf_fifo_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .wclk          (wclk),
    .rclk          (rclk),
    .mrst          (mrst),
    .prst          (prst),
    .wen           (wen),
    .ren           (ren),
    .rdata         (rdata),
    .rd_status     (rd_status),
    .wr_full       (wr_full),
    .wr_level      (wr_level),
    .wr_gray       (wr_gray),
    .rd_gray       (rd_gray),
    .rd_stor_empty (rd_stor_empty),
    .wr_mode       (wr_mode),
    .rd_mode       (rd_mode)
);

// File: tb/test_dcf_fifo.sv
module test_dcf_fifo;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              wclk = 1'b0;
    logic              rclk = 1'b0;
    logic              wen = 1'b0;
    logic              ren = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              mrst = 1'b1;
    logic              prst = 1'b0;
    logic              mode_sel = 1'b0;
    logic              rd_status;
    logic              wr_status;
    logic              half_full;

    int n_chk = 0;
    int n_err = 0;

    always #2 wclk = ~wclk;   // 250 MHz write clock
    always #3 rclk = ~rclk;   // read clock, rising edges never meet write edges

    dcf_fifo #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_dcf_fifo (
        .wclk      (wclk),
        .wen       (wen),
        .wdata     (wdata),
        .rclk      (rclk),
        .ren       (ren),
        .rdata     (rdata),
        .mrst      (mrst),
        .prst      (prst),
        .mode_sel  (mode_sel),
        .rd_status (rd_status),
        .wr_status (wr_status),
        .half_full (half_full)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge rclk);
        @(negedge wclk);
    endtask

    task automatic do_mrst(input logic m);
        @(negedge wclk);
        mrst = 1'b1; mode_sel = m; wen = 1'b0; ren = 1'b0;
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        mrst = 1'b0;
        @(negedge wclk);
        mode_sel = ~m;            // must be ignored from here on (R1)
        settle();
    endtask

    task automatic do_prst();
        @(negedge wclk);
        prst = 1'b1; wen = 1'b0; ren = 1'b0;
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        prst = 1'b0;
        settle();
    endtask

    task automatic push(input logic [DATA_W-1:0] d);
        @(negedge wclk);
        wen = 1'b1; wdata = d;
        @(posedge wclk);
        wen <= 1'b0;
    endtask

    task automatic pop();
        @(negedge rclk);
        ren = 1'b1;
        @(posedge rclk);
        ren <= 1'b0;
        #1;
    endtask

    task automatic t_reset_std();
        do_mrst(1'b0);
        check("R8", "std reset rd_status", 32'(rd_status), 32'd1);
        check("R8", "std reset wr_status", 32'(wr_status), 32'd0);
        check("R8", "reset half_full", 32'(half_full), 32'd0);
        check("R8", "reset rdata", 32'(rdata), 32'd0);
    endtask

    task automatic t_std_order();
        for (int i = 0; i < 5; i++) push(DATA_W'(16'hA0 + i));
        settle();
        check("R2", "std rdata without ren", 32'(rdata), 32'd0);
        check("R5", "std not empty", 32'(rd_status), 32'd0);
        check("R1", "mode_sel flip ignored, still std", 32'(rdata), 32'd0);
        for (int i = 0; i < 5; i++) begin
            pop();
            check("R2", "std read order", 32'(rdata), 32'(16'hA0 + i));
        end
        settle();
        check("R5", "std empty after drain", 32'(rd_status), 32'd1);
    endtask

    task automatic t_std_underflow();
        for (int i = 0; i < 3; i++) pop();
        check("R7", "read while empty keeps rdata", 32'(rdata), 32'h00A4);
        push(16'h5A5A);
        settle();
        pop();
        check("R7", "word after dropped reads", 32'(rdata), 32'h5A5A);
    endtask

    task automatic t_full_half();
        do_mrst(1'b0);
        for (int i = 0; i < DEPTH / 2; i++) push(DATA_W'(16'h100 + i));
        settle();
        check("R6", "half_full at DEPTH/2", 32'(half_full), 32'd0);
        push(DATA_W'(16'h100 + DEPTH / 2));
        settle();
        check("R6", "half_full above DEPTH/2", 32'(half_full), 32'd1);
        for (int i = DEPTH / 2 + 1; i < DEPTH; i++) push(DATA_W'(16'h100 + i));
        settle();
        check("R5", "std full flag", 32'(wr_status), 32'd1);
        for (int i = 0; i < 3; i++) push(16'hDEAD);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            pop();
            check("R7", "order kept past dropped writes", 32'(rdata), 32'(16'h100 + i));
        end
        settle();
        check("R7", "extra writes not stored", 32'(rd_status), 32'd1);
        check("R6", "half_full cleared after drain", 32'(half_full), 32'd0);
    endtask

    task automatic t_fwft_latency();
        do_mrst(1'b1);
        check("R8", "fwft reset rd_status", 32'(rd_status), 32'd0);
        check("R8", "fwft reset wr_status", 32'(wr_status), 32'd1);
        @(negedge wclk);
        wen = 1'b1; wdata = 16'hC001;
        @(posedge wclk);
        wen <= 1'b0;
        @(posedge rclk);
        @(posedge rclk);
        #1;
        check("R3", "not ready after two read edges", 32'(rd_status), 32'd0);
        @(posedge rclk);
        #1;
        check("R3", "ready at third read edge", 32'(rd_status), 32'd1);
        check("R3", "first word falls through", 32'(rdata), 32'hC001);
    endtask

    task automatic t_fwft_next();
        push(16'hC002);
        settle();
        check("R4", "second word waits for ren", 32'(rdata), 32'hC001);
        pop();
        check("R4", "ren presents next word", 32'(rdata), 32'hC002);
        check("R4", "still ready", 32'(rd_status), 32'd1);
        pop();
        check("R4", "ren on last word drops ready", 32'(rd_status), 32'd0);
    endtask

    task automatic t_fwft_fill();
        for (int i = 0; i < DEPTH + 3; i++) push(DATA_W'(16'hB00 + i));
        settle();
        check("R5", "fwft no room", 32'(wr_status), 32'd0);
        check("R6", "fwft half_full", 32'(half_full), 32'd1);
        check("R3", "fwft head word", 32'(rdata), 32'hB00);
        for (int i = 1; i <= DEPTH; i++) begin
            pop();
            check("R7", "fwft order after full", 32'(rdata), 32'(16'hB00 + i));
        end
        pop();
        check("R7", "fwft drops writes beyond capacity", 32'(rd_status), 32'd0);
        settle();
        check("R5", "fwft room again", 32'(wr_status), 32'd1);
    endtask

    task automatic t_partial_reset();
        for (int i = 0; i < 3; i++) push(DATA_W'(16'hE0 + i));
        settle();
        mode_sel = 1'b0;
        do_prst();
        check("R9", "prst clears ready", 32'(rd_status), 32'd0);
        check("R9", "prst keeps fwft input-ready", 32'(wr_status), 32'd1);
        check("R9", "prst clears rdata", 32'(rdata), 32'd0);
        check("R9", "prst clears half_full", 32'(half_full), 32'd0);
        push(16'hE9);
        settle();
        check("R9", "fwft kept after prst", 32'(rd_status), 32'd1);
        check("R9", "fall-through word after prst", 32'(rdata), 32'hE9);
        do_mrst(1'b0);
        push(16'h77);
        settle();
        check("R1", "std after new master reset", 32'(rdata), 32'd0);
        check("R1", "std empty flag low", 32'(rd_status), 32'd0);
        pop();
        check("R1", "std read after mode change", 32'(rdata), 32'h77);
    endtask

    initial begin
        fork
            begin
                t_reset_std();
                t_std_order();
                t_std_underflow();
                t_full_half();
                t_fwft_latency();
                t_fwft_next();
                t_fwft_fill();
                t_partial_reset();
            end
            begin
                #200000;
                n_chk++;
                n_err++;
                $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule